// File: doc/BRIEF.md
# Capture/Compare Timer with Port Actions

This block is a 16-bit up-counter that cannot be loaded. It is fed through a prescaler from one of three sources: a divided system tick, rising edges on an external count pin, or no source at all. Four capture channels watch their own input pins. On the selected edge, a channel copies the running count into its own register. Three compare registers are checked against the counter each time it steps. A match can set, clear or toggle bits of an 8-bit output port, and per-bit enable masks decide which bits react.

Software uses a plain register write/read interface. Through it, software sets the counter source, the division factor, the edge selection, the masks and the compare values. It can also write the port and read back the count and the captured values. Every event raises a sticky flag in one flag vector. Software clears a flag by writing 0 to it. The two overflow flags share a single interrupt request, and each overflow has its own enable. No data stream passes through the block, so every pin is a plain control or status signal, without valid/ready.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the count, all compare registers, the port and the flag vector read 0, and `irq_ovf_o` is low.
- R2: The control register bits [1:0] pick the source: 0 or 3 is off, 1 is `tick_i` pulses, and 2 is rising edges of `cnt_pin_i`. Bits [3:2] hold k, and the counter steps by +1 once per 2^k source pulses. With the source off, the counter never moves.
- R3: A control write that changes the source or the division factor clears the prescaler. A counter reset or idle also clears it.
- R4: When control bit 4 is 1, a rising edge on `crst_pin_i` clears the counter. When that bit is 0, the edge has no effect.
- R5: The edge register (address 1) holds the rising-edge enable of capture channel n in bit 2n and the falling-edge enable in bit 2n+1. When a selected edge arrives, the channel copies the count into its capture register (address 10+n) and sets flag bit n. With neither edge selected, the channel does nothing.
- R6: A match on compare 0 (address 4) sets every port bit 0 to 5 whose set-enable bit (address 2) is 1. Set-enable bits 6 and 7 always read 0.
- R7: A match on compare 1 (address 5) clears every port bit 0 to 5 whose reset/toggle-enable bit (address 3) is 1. When compare 0 and compare 1 match in the same cycle, the clear wins.
- R8: A match on compare 2 (address 6) inverts each of port bits 6 and 7 whose reset/toggle-enable bit is 1.
- R9: Compare matches set flag bits 4 to 6. A low-byte rollover sets flag bit 7, and a 16-bit rollover sets flag bit 8. `irq_ovf_o` is the OR of flag 7 gated by enable bit 0 and flag 8 gated by enable bit 1, both enables at address 14.
- R10: A write to the flag register (address 8) clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A hardware set in the same cycle wins over the clear.
- R11: While control bit 5 (idle) is 1, the counter stays at 0 and does not step.
- R12: A software port write (address 7) in the same cycle as a compare action loads the written value, and the compare action is then applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Divided system tick, one-cycle pulses |
| cnt_pin_i | input | 1 | External count pin, asynchronous |
| crst_pin_i | input | 1 | External counter-reset pin, asynchronous |
| cap_i | input | 4 | Capture input pins, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| port_o | output | 8 | Output port |
| flags_o | output | 9 | Sticky event flags |
| irq_ovf_o | output | 1 | Shared overflow interrupt request |

## Verification
The prescaler is tested with several division factors and pulse counts. Some of these counts are not multiples of the factor, which separates correct division from an off-by-one or an ignored factor. The capture channels each get a different edge mode, and both rising and falling transitions are applied to them. This shows whether rising, falling, both and none are kept apart, and whether a channel samples the count at the right moment. The compare tests step the counter through values where set, clear and toggle act one after another on the same port. Timed collisions are also forced: a flag clear lands exactly on a capture event, and a port write lands exactly on a match. These show which side wins.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_TICK = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_OFF2 = 2'd3
  } src_e;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_EDGE  = 4'd1;
  localparam logic [3:0] A_SETEN = 4'd2;
  localparam logic [3:0] A_RTEN  = 4'd3;
  localparam logic [3:0] A_CMP0  = 4'd4;
  localparam logic [3:0] A_PORT  = 4'd7;
  localparam logic [3:0] A_FLAG  = 4'd8;
  localparam logic [3:0] A_COUNT = 4'd9;
  localparam logic [3:0] A_CAP0  = 4'd10;
  localparam logic [3:0] A_OVFEN = 4'd14;

  localparam int N_CMP  = 3;
  localparam int PORT_W = 8;
  localparam int LO_W   = 8;
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/cct_prescale.sv
module cct_prescale import cct_pkg::*; #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick_i,
  input  logic             pin_rise_i,
  input  logic             clr_i,
  output logic             inc_o
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q, mask;
  logic             pulse;

  always_comb begin
    unique case (src_i)
      SRC_TICK: pulse = tick_i;
      SRC_PIN:  pulse = pin_rise_i;
      default:  pulse = 1'b0;
    endcase
    mask = PRE_W'((1 << div_i) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) pre_q <= '0;
    else if (pulse)      pre_q <= pre_q + 1'b1;
  end

  assign inc_o = pulse && !clr_i && ((pre_q & mask) == mask);
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   cnt_i,
  input  logic [N-1:0]   rise_i,
  input  logic [N-1:0]   fall_i,
  input  logic [2*N-1:0] edge_en_i,
  output logic [N-1:0]   ev_o,
  output logic [N*W-1:0] caps_o
);
  for (genvar n = 0; n < N; n++) begin : g_ch
    logic [W-1:0] cap_q;
    assign ev_o[n] = (rise_i[n] & edge_en_i[2*n]) | (fall_i[n] & edge_en_i[2*n+1]);
    always_ff @(posedge clk) begin
      if (!rst_n)       cap_q <= '0;
      else if (ev_o[n]) cap_q <= cnt_i;
    end
    assign caps_o[n*W +: W] = cap_q;
  end
endmodule

// File: rtl/cct_portlogic.sv
module cct_portlogic import cct_pkg::*; #(
  parameter int SET_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_i,
  input  logic [PORT_W-1:0] sw_data_i,
  input  logic [SET_W-1:0]  seten_i,
  input  logic [PORT_W-1:0] rten_i,
  input  logic [N_CMP-1:0]  match_i,
  output logic [PORT_W-1:0] port_o
);
  localparam int TOG_W = PORT_W - SET_W;

  logic [PORT_W-1:0] port_q, base, set_m, clr_m, tog_m;

  always_comb begin
    base  = sw_wr_i ? sw_data_i : port_q;
    set_m = match_i[0] ? {{TOG_W{1'b0}}, seten_i} : '0;
    clr_m = match_i[1] ? {{TOG_W{1'b0}}, rten_i[SET_W-1:0]} : '0;
    tog_m = match_i[2] ? {rten_i[PORT_W-1:SET_W], {SET_W{1'b0}}} : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) port_q <= '0;
    else        port_q <= ((base | set_m) & ~clr_m) ^ tog_m;
  end

  assign port_o = port_q;
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer import cct_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 4,
  parameter int SET_W = 6,
  parameter int DIV_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   cnt_pin_i,
  input  logic                   crst_pin_i,
  input  logic [N_CAP-1:0]       cap_i,
  input  logic                   wr_en,
  input  logic [3:0]             wr_addr,
  input  logic [CNT_W-1:0]       wr_data,
  input  logic [3:0]             rd_addr,
  output logic [CNT_W-1:0]       rd_data,
  output logic [PORT_W-1:0]      port_o,
  output logic [N_CAP+N_CMP+1:0] flags_o,
  output logic                   irq_ovf_o
);
  localparam int NFLAG = N_CAP + N_CMP + 2;
  localparam int F_LO  = N_CAP + N_CMP;
  localparam int F_HI  = F_LO + 1;

  src_e                src_q;
  logic [DIV_W-1:0]    div_q;
  logic                crst_en_q, idle_q;
  logic [2*N_CAP-1:0]  edge_q;
  logic [SET_W-1:0]    seten_q;
  logic [PORT_W-1:0]   rten_q;
  logic [CNT_W-1:0]    cmp_q [N_CMP];
  logic [1:0]          ovfen_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [NFLAG-1:0]    flags_q, flag_set, flag_clr;
  logic                inc, inc_d, pre_clr, crst_hit, ctrl_wr;
  logic                cnt_rise, crst_rise, cnt_fall_nc, crst_fall_nc;
  logic [N_CAP-1:0]    cap_rise, cap_fall, cap_ev;
  logic [N_CAP*CNT_W-1:0] caps;
  logic [N_CMP-1:0]    match;
  logic [3:0]          cidx;

  cct_sync #(.W(2)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_i({crst_pin_i, cnt_pin_i}),
    .rise_o({crst_rise, cnt_rise}), .fall_o({crst_fall_nc, cnt_fall_nc})
  );

  cct_sync #(.W(N_CAP)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cap_i), .rise_o(cap_rise), .fall_o(cap_fall)
  );

  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign crst_hit = crst_en_q && crst_rise;
  assign pre_clr  = idle_q || crst_hit ||
                    (ctrl_wr && ((wr_data[1:0] != src_q) || (wr_data[2 +: DIV_W] != div_q)));

  cct_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_i(src_q), .div_i(div_q), .tick_i(tick_i),
    .pin_rise_i(cnt_rise), .clr_i(pre_clr), .inc_o(inc)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= SRC_OFF;
      div_q     <= '0;
      crst_en_q <= 1'b0;
      idle_q    <= 1'b0;
      edge_q    <= '0;
      seten_q   <= '0;
      rten_q    <= '0;
      ovfen_q   <= '0;
      for (int k = 0; k < N_CMP; k++) cmp_q[k] <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          src_q     <= src_e'(wr_data[1:0]);
          div_q     <= wr_data[2 +: DIV_W];
          crst_en_q <= wr_data[4];
          idle_q    <= wr_data[5];
        end
        A_EDGE:  edge_q  <= wr_data[2*N_CAP-1:0];
        A_SETEN: seten_q <= wr_data[SET_W-1:0];
        A_RTEN:  rten_q  <= wr_data[PORT_W-1:0];
        A_OVFEN: ovfen_q <= wr_data[1:0];
        default: begin
          for (int k = 0; k < N_CMP; k++)
            if (wr_addr == A_CMP0 + 4'(k)) cmp_q[k] <= wr_data;
        end
      endcase
    end
  end

  // Counter: reset-only, never loaded
  always_ff @(posedge clk) begin
    if (!rst_n || idle_q || crst_hit) cnt_q <= '0;
    else if (inc)                     cnt_q <= cnt_q + 1'b1;
    inc_d <= rst_n && inc && !idle_q && !crst_hit;
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    assign match[k] = inc_d && (cnt_q == cmp_q[k]);
  end

  cct_capture #(.N(N_CAP), .W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_q), .rise_i(cap_rise), .fall_i(cap_fall),
    .edge_en_i(edge_q), .ev_o(cap_ev), .caps_o(caps)
  );

  cct_portlogic #(.SET_W(SET_W)) u_port (
    .clk(clk), .rst_n(rst_n), .sw_wr_i(wr_en && (wr_addr == A_PORT)),
    .sw_data_i(wr_data[PORT_W-1:0]), .seten_i(seten_q), .rten_i(rten_q),
    .match_i(match), .port_o(port_o)
  );

  // Sticky flags: clear by writing 0, hardware set wins
  always_comb begin
    flag_set = {inc && (&cnt_q), inc && (&cnt_q[LO_W-1:0]), match, cap_ev};
    flag_clr = (wr_en && (wr_addr == A_FLAG)) ? ~wr_data[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign flags_o   = flags_q;
  assign irq_ovf_o = (flags_q[F_LO] & ovfen_q[0]) | (flags_q[F_HI] & ovfen_q[1]);

  // Read mux
  assign cidx = rd_addr - A_CAP0;
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:  rd_data = CNT_W'({idle_q, crst_en_q, div_q, src_q});
      A_EDGE:  rd_data = CNT_W'(edge_q);
      A_SETEN: rd_data = CNT_W'(seten_q);
      A_RTEN:  rd_data = CNT_W'(rten_q);
      A_PORT:  rd_data = CNT_W'(port_o);
      A_FLAG:  rd_data = CNT_W'(flags_q);
      A_COUNT: rd_data = cnt_q;
      A_OVFEN: rd_data = CNT_W'(ovfen_q);
      default: begin
        for (int k = 0; k < N_CMP; k++)
          if (rd_addr == A_CMP0 + 4'(k)) rd_data = cmp_q[k];
        for (int n = 0; n < N_CAP; n++)
          if (cidx == 4'(n) && rd_addr >= A_CAP0) rd_data = caps[n*CNT_W +: CNT_W];
      end
    endcase
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CNT_W = 16,
  parameter int N_CAP = 4,
  parameter int NFLAG = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CNT_W-1:0]       cnt,
  input logic [NFLAG-1:0]       flags,
  input logic [N_CAP*CNT_W-1:0] caps,
  input logic                   idle,
  input logic                   flag_wr
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt == '0)); // R11

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0))); // R2

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flags & $past(flags)) == $past(flags))); // R10

  for (genvar n = 0; n < N_CAP; n++) begin : g_cap
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(caps[n*CNT_W +: CNT_W]) |-> flags[n]); // R5
  end
endmodule

bind capcmp_timer cct_checker #(.CNT_W(CNT_W), .N_CAP(N_CAP), .NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .flags(flags_q), .caps(caps),
  .idle(idle_q), .flag_wr(wr_en && (wr_addr == 4'd8))
);

// File: tb/sim_capcmp_timer.sv
module sim_capcmp_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick_i = 0, cnt_pin_i = 0, crst_pin_i = 0;
  logic [3:0] cap_i = '0;
  logic wr_en = 0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [7:0] port_o;
  logic [8:0] flags_o;
  logic irq_ovf_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
    .crst_pin_i(crst_pin_i), .cap_i(cap_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .port_o(port_o),
    .flags_o(flags_o), .irq_ovf_o(irq_ovf_o)
  );

  // {div[15:14], tick pulses[13:8], expected count[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {2'd0, 6'd5,  8'd5}, {2'd1, 6'd5,  8'd2}, {2'd2, 6'd9,  8'd2},
    {2'd3, 6'd17, 8'd2}, {2'd3, 6'd7,  8'd0}, {2'd1, 6'd1,  8'd0}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
      @(negedge clk);
    end
  endtask

  task automatic zero_count();
    wr(4'd0, 16'h0020);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);

    // R1 reset state
    rd(4'd9, v); chk("R1 count", v, 16'h0);
    rd(4'd4, v); chk("R1 cmp0", v, 16'h0);
    rd(4'd6, v); chk("R1 cmp2", v, 16'h0);
    chk("R1 port", {8'h0, port_o}, 16'h0);
    chk("R1 flags", {7'h0, flags_o}, 16'h0);
    chk("R1 irq", {15'h0, irq_ovf_o}, 16'h0);

    // R2 table of division factors
    for (int i = 0; i < 6; i++) begin
      zero_count();
      wr(4'd0, {12'h0, VEC[i][15:14], 2'b01});
      ticks(int'(VEC[i][13:8]));
      rd(4'd9, v); chk($sformatf("R2 div vec %0d", i), v, {8'h0, VEC[i][7:0]});
    end

    // R2 source off ignores ticks
    zero_count();
    wr(4'd0, 16'h0000);
    ticks(4);
    rd(4'd9, v); chk("R2 source off", v, 16'h0);

    // R2 external pin source
    wr(4'd0, 16'h0002);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); cnt_pin_i = 1; wait_cyc(2);
      cnt_pin_i = 0; wait_cyc(2);
    end
    wait_cyc(3);
    rd(4'd9, v); chk("R2 pin source", v, 16'd3);

    // R3 prescaler clears on division change
    zero_count();
    wr(4'd0, 16'h0009);
    ticks(3);
    wr(4'd0, 16'h000D);
    ticks(5);
    rd(4'd9, v); chk("R3 prescaler cleared", v, 16'd0);

    // R4 external counter reset
    zero_count();
    wr(4'd0, 16'h0001);
    ticks(4);
    @(negedge clk); crst_pin_i = 1; wait_cyc(4); crst_pin_i = 0; wait_cyc(3);
    rd(4'd9, v); chk("R4 reset disabled", v, 16'd4);
    wr(4'd0, 16'h0011);
    @(negedge clk); crst_pin_i = 1; wait_cyc(4); crst_pin_i = 0; wait_cyc(3);
    rd(4'd9, v); chk("R4 reset enabled", v, 16'd0);

    // R5 capture edge modes: ch0 rise, ch1 fall, ch2 both, ch3 none
    zero_count();
    wr(4'd0, 16'h0001);
    ticks(6);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'h0039);
    wr(4'd8, 16'h0000);
    @(negedge clk); cap_i = 4'hF; wait_cyc(5);
    chk("R5 rising flags", {12'h0, flags_o[3:0]}, 16'h0005);
    rd(4'd10, v); chk("R5 cap0 value", v, 16'd6);
    rd(4'd12, v); chk("R5 cap2 value", v, 16'd6);
    wr(4'd8, 16'h0000);
    wr(4'd0, 16'h0001);
    ticks(1);
    wr(4'd0, 16'h0000);
    @(negedge clk); cap_i = 4'h0; wait_cyc(5);
    chk("R5 falling flags", {12'h0, flags_o[3:0]}, 16'h0006);
    rd(4'd11, v); chk("R5 cap1 value", v, 16'd7);
    rd(4'd10, v); chk("R5 cap0 held", v, 16'd6);
    rd(4'd13, v); chk("R5 cap3 unused", v, 16'd0);

    // R10 hardware set wins over a same-cycle clear
    wr(4'd8, 16'h0000);
    @(negedge clk); cap_i = 4'h1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; wr_addr = 4'd8; wr_data = 16'h0000;
    @(negedge clk); wr_en = 0;
    chk("R10 set wins", {15'h0, flags_o[0]}, 16'h1);
    wr(4'd8, 16'hFFFE);
    chk("R10 cleared by zero", {15'h0, flags_o[0]}, 16'h0);
    cap_i = 4'h0; wait_cyc(5);
    wr(4'd8, 16'h0000);

    // R6 R7 R8 compare actions on the port
    zero_count();
    wr(4'd7, 16'h0000);
    wr(4'd2, 16'h00FF);
    rd(4'd2, v); chk("R6 seten readback", v, 16'h003F);
    wr(4'd3, 16'h00C5);
    wr(4'd4, 16'd2);
    wr(4'd5, 16'd4);
    wr(4'd6, 16'd3);
    wr(4'd0, 16'h0001);
    ticks(2);
    chk("R6 set on cmp0", {8'h0, port_o}, 16'h003F);
    ticks(1);
    chk("R8 toggle on cmp2", {8'h0, port_o}, 16'h00FF);
    ticks(1);
    chk("R7 clear on cmp1", {8'h0, port_o}, 16'h00FA);
    chk("R9 compare flags", {13'h0, flags_o[6:4]}, 16'h0007);

    // R12 software port write in the match cycle
    wr(4'd2, 16'h0001);
    wr(4'd4, 16'd5);
    @(negedge clk); tick_i = 1;
    @(negedge clk); tick_i = 0; wr_en = 1; wr_addr = 4'd7; wr_data = 16'h0080;
    @(negedge clk); wr_en = 0;
    chk("R12 sw write plus set", {8'h0, port_o}, 16'h0081);

    // R11 idle holds the counter at zero
    ticks(2);
    wr(4'd0, 16'h0021);
    ticks(3);
    rd(4'd9, v); chk("R11 idle count", v, 16'd0);

    // R9 overflow flags and shared request
    wr(4'd0, 16'h0001);
    wr(4'd8, 16'h0000);
    wr(4'd14, 16'h0001);
    @(negedge clk); tick_i = 1;
    wait_cyc(256);
    tick_i = 0;
    rd(4'd9, v); chk("R9 count after 256", v, 16'd256);
    chk("R9 low overflow", {14'h0, flags_o[8:7]}, 16'h0001);
    chk("R9 irq low", {15'h0, irq_ovf_o}, 16'h1);
    wr(4'd14, 16'h0000);
    chk("R9 irq masked", {15'h0, irq_ovf_o}, 16'h0);
    @(negedge clk); tick_i = 1;
    wait_cyc(65280);
    tick_i = 0;
    rd(4'd9, v); chk("R9 wrap count", v, 16'd0);
    chk("R9 full overflow", {15'h0, flags_o[8]}, 16'h1);
    wr(4'd14, 16'h0002);
    chk("R9 irq full", {15'h0, irq_ovf_o}, 16'h1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule